// File: doc/BRIEF.md
# BT.656 Timing Reference Decoder

This block watches an 8-bit multiplexed 4:2:2 byte stream and pulls the embedded timing reference codes out of it. A code is a three-byte preamble (0xFF, 0x00, 0x00) followed by a status word. From the status word the block rebuilds the line timing:

- a horizontal sync pulse after every end-of-active-video code;
- level signals for field identity and vertical blanking, which change only at end-of-active-video codes;
- a flag that marks the active part of a video line;
- a luma/chroma byte-phase indicator;
- an error flag for status words that fail their protection check.

A line-length meter counts the samples between consecutive end-of-active-video codes. It reports whether the stream follows 625-line timing or 525-line timing.

Every byte is qualified by a sample-gate input. When the gate is held low, every clock edge takes a byte. When a half-rate clock drives the gate, only every other edge does. This lets a front end that delivers data at half rate feed the block directly. The block has an asynchronous active-low reset. Its release is synchronised internally, so the outputs leave reset a few clocks after the reset pin goes high.

Top module: `bt656_ref_decoder`

## Requirements
- R1: While in reset and until the first valid code arrives, the outputs sit idle: hsync_o=0, field_o=0, vblank_o=1, active_o=0, err_o=0, std_valid_o=0.
- R2: A byte is accepted only on a clock edge where sample_gate is low. On edges where it is high, din is ignored and no output or internal state changes. Gated bytes also do not break a preamble.
- R3: A status word is an accepted byte that directly follows the accepted bytes 0xFF, 0x00, 0x00 in that order. Its bit 7 must be 1. Bit 6 is F, bit 5 is V, bit 4 is H (1 = end of active video, 0 = start of active video), and bits 3..0 are P3..P0.
- R4: A status word is valid only if bit 7 is 1 and P3=V^H, P2=F^H, P1=F^V, P0=F^V^H. An invalid word raises err_o for one accepted-sample period and is otherwise discarded: no hsync, no field, blanking or active change, and no line-counter restart.
- R5: A valid end-of-active-video word drives hsync_o high from the edge that accepts it until the next accepted sample. It stays high across gated clocks in between.
- R6: field_o and vblank_o take F and V from valid end-of-active-video words, on the same edge as hsync_o. Start-of-active-video words leave them unchanged.
- R7: A valid start-of-active-video word with V=0 sets active_o. One with V=1 leaves it low. Every valid end-of-active-video word clears it.
- R8: phase_o is 0 after a valid start-of-active-video word (next byte is chroma) and toggles with every further accepted byte.
- R9: The line period is the number of accepted samples from one valid end-of-active-video status word to the next. A period of 1728 is classed 625-line, 1716 is classed 525-line, and any other value is unknown.
- R10: The standard outputs change only at a valid end-of-active-video word, and only when the two latest periods share a class. A shared known class sets std_valid_o=1 and std_625_o=1 for 625-line or 0 for 525-line. A shared unknown class clears std_valid_o and leaves std_625_o unchanged. The first valid end-of-active-video word after reset yields no period, so std_valid_o can first rise at the third one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_gate | input | 1 | Byte taken on edges where this is low |
| din | input | 8 | Multiplexed video byte stream |
| hsync_o | output | 1 | One-sample pulse after end of active video |
| field_o | output | 1 | Field identity (0 first, 1 second) |
| vblank_o | output | 1 | Vertical blanking level |
| active_o | output | 1 | High during the active part of a video line |
| phase_o | output | 1 | Kind of next byte: 0 chroma, 1 luma |
| err_o | output | 1 | Protection or lead-bit error pulse |
| std_valid_o | output | 1 | Line standard has been established |
| std_625_o | output | 1 | 1 = 625-line timing, 0 = 525-line timing |

## Verification
The embedded assertions check four rules on every cycle:
- a gated edge freezes all timing outputs;
- hsync only follows a valid end-of-active-video word;
- field and blanking move only at such a word;
- a rejected word leaves the sync and active state alone, and the line counter restarts exactly at each valid end-of-active-video word.

Other properties only the bench scenarios can show. These are the exact line lengths that produce each standard class, the two-line agreement and hold behaviour across changing line lengths, preambles split by gated clocks, near-miss preambles, and the idle state after a mid-stream reset.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

  typedef enum logic [1:0] {
    LS_NONE = 2'd0,
    LS_525  = 2'd1,
    LS_625  = 2'd2
  } line_cls_e;

  typedef struct packed {
    logic       lead;
    logic       fld;
    logic       vbl;
    logic       eav;
    logic [3:0] prot;
  } trs_word_t;

  function automatic logic [3:0] prot_bits(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/bt656_rst_sync.sv
module bt656_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bt656_trs_finder.sv
module bt656_trs_finder #(
  parameter int DW      = 8,
  parameter int PRE_LEN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic [DW-1:0] din,
  output logic          word_hit
);
  // hist_q[0] is the newest accepted byte, hist_q[PRE_LEN-1] the oldest
  logic [DW-1:0]      hist_q [PRE_LEN];
  logic [DW-1:0]      hist_d [PRE_LEN];
  logic [PRE_LEN-1:0] pat_m;

  always_comb begin
    hist_d = hist_q;
    if (smp_en) begin
      hist_d[0] = din;
      for (int i = 1; i < PRE_LEN; i++) hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  for (genvar g = 0; g < PRE_LEN; g++) begin : g_pat
    if (g == PRE_LEN - 1) begin : g_ones
      assign pat_m[g] = (hist_q[g] == '1);
    end else begin : g_zero
      assign pat_m[g] = (hist_q[g] == '0);
    end
  end

  assign word_hit = smp_en & (&pat_m);
endmodule

// File: rtl/bt656_word_check.sv
module bt656_word_check (
  input  logic [7:0] word,
  output logic       word_ok,
  output logic       fld,
  output logic       vbl,
  output logic       eav
);
  import bt656_pkg::*;

  trs_word_t w;

  assign w       = word;
  assign fld     = w.fld;
  assign vbl     = w.vbl;
  assign eav     = w.eav;
  assign word_ok = w.lead && (w.prot == prot_bits(w.fld, w.vbl, w.eav));
endmodule

// File: rtl/bt656_sync_gen.sv
module bt656_sync_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic word_hit,
  input  logic word_ok,
  input  logic fld,
  input  logic vbl,
  input  logic eav,
  output logic hsync,
  output logic field,
  output logic vblank,
  output logic active,
  output logic phase,
  output logic err
);
  logic hs_q, fld_q, vbl_q, act_q, ph_q, err_q;
  logic hs_d, fld_d, vbl_d, act_d, ph_d, err_d;

  always_comb begin
    hs_d  = hs_q;
    fld_d = fld_q;
    vbl_d = vbl_q;
    act_d = act_q;
    ph_d  = ph_q;
    err_d = err_q;
    if (smp_en) begin
      hs_d  = 1'b0;
      err_d = 1'b0;
      ph_d  = ~ph_q;
      if (word_hit) begin
        if (!word_ok) begin
          err_d = 1'b1;
        end else if (eav) begin
          hs_d  = 1'b1;
          fld_d = fld;
          vbl_d = vbl;
          act_d = 1'b0;
        end else begin
          act_d = ~vbl;
          ph_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      fld_q <= 1'b0;
      vbl_q <= 1'b1;
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hs_q  <= hs_d;
      fld_q <= fld_d;
      vbl_q <= vbl_d;
      act_q <= act_d;
      ph_q  <= ph_d;
      err_q <= err_d;
    end
  end

  assign hsync  = hs_q;
  assign field  = fld_q;
  assign vblank = vbl_q;
  assign active = act_q;
  assign phase  = ph_q;
  assign err    = err_q;

  AST_NO_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable({hs_q, fld_q, vbl_q, act_q, ph_q, err_q})); // R2
  AST_BAD_WORD_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && word_hit && !word_ok) |=> (!hs_q && err_q && $stable(act_q))); // R4
  AST_HSYNC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !(word_hit && word_ok && eav)) |=> !hs_q); // R5
  AST_FV_ONLY_AT_EAV: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_en && word_hit && word_ok && eav) |=> ($stable(fld_q) && $stable(vbl_q))); // R6
endmodule

// File: rtl/bt656_line_meter.sv
module bt656_line_meter #(
  parameter int CNT_W   = 12,
  parameter int LEN_625 = 1728,
  parameter int LEN_525 = 1716
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic eav_strobe,
  output logic std_valid,
  output logic std_625
);
  import bt656_pkg::*;

  localparam logic [CNT_W:0]   PER_625 = (CNT_W + 1)'(LEN_625);
  localparam logic [CNT_W:0]   PER_525 = (CNT_W + 1)'(LEN_525);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   period;
  line_cls_e        cls, prev_q, prev_d;
  logic             run_q, run_d;
  logic             have_q, have_d;
  logic             vld_q, vld_d;
  logic             s625_q, s625_d;

  assign period = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    if (cnt_q == CNT_MAX)      cls = LS_NONE;
    else if (period == PER_625) cls = LS_625;
    else if (period == PER_525) cls = LS_525;
    else                        cls = LS_NONE;
  end

  always_comb begin
    cnt_d  = cnt_q;
    prev_d = prev_q;
    run_d  = run_q;
    have_d = have_q;
    vld_d  = vld_q;
    s625_d = s625_q;
    if (smp_en) begin
      if (eav_strobe) cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
    if (eav_strobe) begin
      run_d = 1'b1;
      if (run_q) begin
        if (have_q && (prev_q == cls)) begin
          if (cls == LS_NONE) begin
            vld_d = 1'b0;
          end else begin
            vld_d  = 1'b1;
            s625_d = (cls == LS_625);
          end
        end
        prev_d = cls;
        have_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= LS_NONE;
      run_q  <= 1'b0;
      have_q <= 1'b0;
      vld_q  <= 1'b0;
      s625_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
      run_q  <= run_d;
      have_q <= have_d;
      vld_q  <= vld_d;
      s625_q <= s625_d;
    end
  end

  assign std_valid = vld_q;
  assign std_625   = s625_q;

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    eav_strobe |=> (cnt_q == '0)); // R9
  AST_STD_ONLY_AT_EAV: assert property (@(posedge clk) disable iff (!rst_n)
    !eav_strobe |=> ($stable(vld_q) && $stable(s625_q))); // R10
  AST_STD_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(have_q)); // R10
endmodule

// File: rtl/bt656_ref_decoder.sv
module bt656_ref_decoder #(
  parameter int CNT_W      = 12,
  parameter int LEN_625    = 1728,
  parameter int LEN_525    = 1716,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_gate,
  input  logic [7:0] din,
  output logic       hsync_o,
  output logic       field_o,
  output logic       vblank_o,
  output logic       active_o,
  output logic       phase_o,
  output logic       err_o,
  output logic       std_valid_o,
  output logic       std_625_o
);
  localparam int DW      = 8;
  localparam int PRE_LEN = 3;

  logic rst_sync_n;
  logic smp_en;
  logic word_hit, word_ok, w_fld, w_vbl, w_eav;
  logic eav_strobe;

  assign smp_en     = ~sample_gate;
  assign eav_strobe = word_hit & word_ok & w_eav;

  bt656_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bt656_trs_finder #(.DW(DW), .PRE_LEN(PRE_LEN)) u_find (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .smp_en   (smp_en),
    .din      (din),
    .word_hit (word_hit)
  );

  bt656_word_check u_chk (
    .word    (din),
    .word_ok (word_ok),
    .fld     (w_fld),
    .vbl     (w_vbl),
    .eav     (w_eav)
  );

  bt656_sync_gen u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .smp_en   (smp_en),
    .word_hit (word_hit),
    .word_ok  (word_ok),
    .fld      (w_fld),
    .vbl      (w_vbl),
    .eav      (w_eav),
    .hsync    (hsync_o),
    .field    (field_o),
    .vblank   (vblank_o),
    .active   (active_o),
    .phase    (phase_o),
    .err      (err_o)
  );

  bt656_line_meter #(.CNT_W(CNT_W), .LEN_625(LEN_625), .LEN_525(LEN_525)) u_meter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .smp_en     (smp_en),
    .eav_strobe (eav_strobe),
    .std_valid  (std_valid_o),
    .std_625    (std_625_o)
  );

  AST_HSYNC_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hsync_o && err_o)); // R4
endmodule

// File: tb/bt656_ref_decoder_tb_top.sv
`timescale 1ns/1ps
module bt656_ref_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_gate;
  logic [7:0] din;
  logic hsync_o, field_o, vblank_o, active_o, phase_o, err_o, std_valid_o, std_625_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  half  = 1'b0;

  always #2.5 clk = ~clk;

  bt656_ref_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sample_gate(sample_gate), .din(din),
    .hsync_o(hsync_o), .field_o(field_o), .vblank_o(vblank_o), .active_o(active_o),
    .phase_o(phase_o), .err_o(err_o), .std_valid_o(std_valid_o), .std_625_o(std_625_o)
  );

  typedef struct packed {
    logic [11:0] len;
    logic        f;
    logic        v;
    logic        hr;
    logic        sv;
    logic        s6;
  } row_t;

  // one row per line: expected standard outputs right after the row's opening EAV
  localparam row_t TBL [11] = '{
    '{12'd1728, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{12'd1728, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'd1728, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{12'd1716, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{12'd1716, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{12'd1716, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{12'd1700, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{12'd1700, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{12'd1728, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{12'd1728, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'd1728, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic gated(input logic [7:0] junk);
    @(negedge clk);
    sample_gate = 1'b1;
    din = junk;
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] b);
    if (half) gated(8'hFF);
    @(negedge clk);
    sample_gate = 1'b0;
    din = b;
    @(posedge clk);
    #1;
  endtask

  task automatic code(input logic [7:0] st);
    put(8'hFF); put(8'h00); put(8'h00); put(st);
  endtask

  task automatic idle_chk(input string tag);
    chk("R1", {tag, " hsync"},  hsync_o, 0);
    chk("R1", {tag, " field"},  field_o, 0);
    chk("R1", {tag, " vblank"}, vblank_o, 1);
    chk("R1", {tag, " active"}, active_o, 0);
    chk("R1", {tag, " err"},    err_o, 0);
    chk("R1", {tag, " std_valid"}, std_valid_o, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_gate = 1'b0;
    din = 8'h00;
    #1;
    idle_chk("in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    idle_chk("after reset");
  endtask

  task automatic send_line(input row_t r, input int idx);
    int hb;
    hb = (r.len == 12'd1728) ? 288 : 276;
    half = r.hr;
    code(mk(r.f, r.v, 1'b1));
    chk("R5", $sformatf("row%0d hsync", idx), hsync_o, 1);
    chk("R6", $sformatf("row%0d field", idx), field_o, r.f);
    chk("R6", $sformatf("row%0d vblank", idx), vblank_o, r.v);
    chk("R7", $sformatf("row%0d active cleared", idx), active_o, 0);
    chk("R4", $sformatf("row%0d err", idx), err_o, 0);
    chk("R10", $sformatf("row%0d std_valid", idx), std_valid_o, r.sv);
    chk("R9", $sformatf("row%0d std_625", idx), std_625_o, r.s6);
    for (int i = 0; i < hb - 8; i++) begin
      put(i[0] ? 8'h10 : 8'h80);
      if (i == 0) chk("R5", $sformatf("row%0d hsync end", idx), hsync_o, 0);
    end
    code(mk(r.f, r.v, 1'b0));
    chk("R7", $sformatf("row%0d active", idx), active_o, !r.v);
    chk("R8", $sformatf("row%0d phase after SAV", idx), phase_o, 0);
    chk("R6", $sformatf("row%0d field kept at SAV", idx), field_o, r.f);
    for (int i = 0; i < int'(r.len) - hb; i++) begin
      put(i[0] ? 8'h50 : 8'h80);
      if (i == 0) chk("R8", $sformatf("row%0d phase toggles", idx), phase_o, 1);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sample_gate = 1'b0;
    din = 8'h00;
    do_reset();

    for (int k = 0; k < 11; k++) send_line(TBL[k], k);
    half = 1'b0;

    // protection mismatch: word discarded, field 1 / vblank 1 kept
    code(mk(1'b0, 1'b0, 1'b1) ^ 8'h01);
    chk("R4", "bad prot err", err_o, 1);
    chk("R4", "bad prot hsync", hsync_o, 0);
    chk("R4", "bad prot field", field_o, 1);
    chk("R4", "bad prot vblank", vblank_o, 1);
    put(8'h80);
    chk("R4", "err one sample", err_o, 0);

    // lead bit clear
    code(mk(1'b0, 1'b0, 1'b1) & 8'h7F);
    chk("R4", "lead bit err", err_o, 1);
    chk("R4", "lead bit field", field_o, 1);
    put(8'h80);

    // a full code presented only on gated edges is ignored
    gated(8'hFF); gated(8'h00); gated(8'h00); gated(mk(1'b0, 1'b0, 1'b1));
    chk("R2", "gated code hsync", hsync_o, 0);
    chk("R2", "gated code field", field_o, 1);
    chk("R2", "gated code vblank", vblank_o, 1);
    put(8'h80);
    chk("R2", "gated code after", field_o, 1);

    // preamble split by gated junk is still recognised
    put(8'hFF); gated(8'h00); put(8'h00); gated(8'hFF); put(8'h00);
    put(mk(1'b0, 1'b0, 1'b1));
    chk("R3", "split code hsync", hsync_o, 1);
    chk("R3", "split code field", field_o, 0);
    chk("R3", "split code vblank", vblank_o, 0);
    gated(8'h80);
    chk("R5", "hsync held over gated edge", hsync_o, 1);
    put(8'h80);
    chk("R5", "hsync after next sample", hsync_o, 0);

    // near-miss preamble
    put(8'hFF); put(8'h00); put(8'h01); put(mk(1'b1, 1'b1, 1'b1));
    chk("R3", "near miss hsync", hsync_o, 0);
    chk("R3", "near miss field", field_o, 0);
    chk("R3", "near miss err", err_o, 0);

    // SAV with F=1: active set, field not changed
    code(mk(1'b1, 1'b0, 1'b0));
    chk("R7", "SAV active", active_o, 1);
    chk("R6", "SAV keeps field", field_o, 0);
    chk("R8", "SAV phase", phase_o, 0);
    put(8'h80);
    chk("R8", "phase luma", phase_o, 1);
    put(8'h80);
    chk("R8", "phase chroma", phase_o, 0);

    // move to field 1, then reset mid-stream
    code(mk(1'b1, 1'b0, 1'b1));
    chk("R6", "pre-reset field", field_o, 1);
    chk("R7", "EAV clears active", active_o, 0);
    do_reset();

    code(mk(1'b1, 1'b0, 1'b1));
    chk("R6", "post-reset field", field_o, 1);
    chk("R6", "post-reset vblank", vblank_o, 0);
    chk("R10", "first EAV no standard", std_valid_o, 0);

    finish_run();
  end
endmodule